// File: doc/BRIEF.md
# Bus-Match Debug Trigger Unit

This block sits beside a CPU bus and watches every access, given as an address, a read/write direction and a valid strobe. Two address comparators, A and B, each hold an address supplied by the debug host. Each one can also be told to fire only on reads or only on writes. A hit on either comparator is a trigger. An 8-bit control register enables the unit, arms a debug run, and selects whether a trigger raises a break request toward the CPU. It also selects whether that request is a tag-type or a force-type request, and holds the per-comparator direction settings.

While a run is armed, the unit records bus addresses into an 8-entry trace buffer. In end-trace mode it records every access and drops the oldest entry when the buffer is full. In that mode the run finishes on the trigger access, which is the last entry recorded. In begin-trace mode recording starts with the trigger access, and the run finishes when the buffer fills. When a run finishes, the arm bit clears and at most one single-cycle break pulse is issued. After the run, the host drains the buffer one entry at a time.

Top module: `dbgtrig_unit`

## Requirements
- R1: The control register resets to 0x00 and reads back on `reg_rdata` at all times. Its bits are: [7] enable, [6] arm, [5] tag-select, [4] break-enable, [3] direction value for A, [2] direction qualify for A, [1] direction value for B, [0] direction qualify for B. A write (`reg_wr_en` high) loads all bits on the next clock edge.
- R2: A write while `secure` is high leaves the enable bit 0. The arm bit can only be set by a write that also leaves enable set, so arm is never 1 while enable is 0.
- R3: A write that sets arm starts a fresh run and empties the trace buffer. After any write, `armed_flag` equals the arm bit written, and `armed_flag` keeps that value when the run later finishes by itself.
- R4: A write that leaves arm or enable at 0 stops a run at once: from the next cycle onward, no access is recorded and no break is issued.
- R5: A comparator hits when `bus_valid` is high and `bus_addr` equals its address. If its qualify bit is 1, the access must also be a read when its value bit is 1, or a write when its value bit is 0. `bus_rd` is 1 for a read. If its qualify bit is 0, the direction is ignored. The trigger is the OR of the A and B hits.
- R6: In end-trace mode (`trace_begin` = 0), every valid access while armed is recorded. When 8 entries are held, a new entry replaces the oldest. The run finishes on the trigger access, which is the last entry recorded.
- R7: In begin-trace mode (`trace_begin` = 1), accesses before the trigger are not recorded. The trigger access and those after it are recorded, and the run finishes on the access that writes the eighth entry.
- R8: When a run finishes with break-enable set, exactly one of `brk_tag` (tag-select 1) or `brk_force` (tag-select 0) is high for one cycle, in the cycle after the finishing access. With break-enable clear, neither output ever pulses and tag-select has no effect.
- R9: The arm bit reads 0 in the same cycle as the break pulse. If breaks are disabled, it reads 0 in the cycle the pulse would have appeared.
- R10: `trace_data` shows the oldest recorded address whenever `trace_count` is nonzero. `trace_full` is high exactly when `trace_count` is 8. `trace_pop` removes one entry only while disarmed, with no write that cycle and a nonempty buffer; at any other time it is ignored.
- R11: A bus access in a cycle with a register write is neither recorded nor treated as a trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write value |
| reg_rdata | output | 8 | Control register read value |
| secure | input | 1 | Blocks setting the enable bit when high |
| trace_begin | input | 1 | 1 = begin-trace mode, 0 = end-trace mode |
| cmp_a_addr | input | 16 | Comparator A address |
| cmp_b_addr | input | 16 | Comparator B address |
| bus_valid | input | 1 | Bus access strobe |
| bus_addr | input | 16 | Bus access address |
| bus_rd | input | 1 | 1 = read access, 0 = write access |
| trace_pop | input | 1 | Remove the oldest trace entry |
| trace_data | output | 16 | Oldest trace entry |
| trace_count | output | 4 | Number of trace entries held |
| trace_full | output | 1 | Trace buffer holds 8 entries |
| armed_flag | output | 1 | Armed-status flag |
| brk_tag | output | 1 | Tag-type break request pulse |
| brk_force | output | 1 | Force-type break request pulse |

## Verification
The bench first goes after end-trace wraparound: a design that overwrites the wrong slot would show a stale oldest address once more than eight accesses precede the trigger. It then checks that direction-qualified comparators ignore an access of the wrong direction, so a unit that drops the qualify bit would trigger too early. It also checks that begin-trace mode finishes on the eighth entry and not the ninth, and that a manual disarm stops recording at once. Finally, it checks that accesses during a register write and pops while armed leave the buffer untouched; a design that gets either wrong would show a count that drifts from the model.

// File: rtl/dbgtrig_pkg.sv
// Shared types for the debug trigger unit.
// Assumes the control register is eight bits with enable in the top bit.
package dbgtrig_pkg;

    typedef struct packed {
        logic en;
        logic arm;
        logic tag;
        logic brk_en;
        logic rw_a;
        logic rw_a_en;
        logic rw_b;
        logic rw_b_en;
    } dbg_ctrl_t;

    localparam int NUM_CMP = 2;

endpackage

// File: rtl/dbgtrig_cmp.sv
// Address comparator with optional read/write direction qualification.
// Assumes bus_rd is 1 for a read; purely combinational.
module dbgtrig_cmp #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] cmp_addr,
    input  logic              rw_val,
    input  logic              rw_qual,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    output logic              hit
);

    // Hit when address matches and direction is acceptable.
    always_comb begin
        hit = bus_valid && (bus_addr == cmp_addr) && (!rw_qual || (bus_rd == rw_val));
    end

endmodule

// File: rtl/dbgtrig_trace.sv
// Circular trace buffer; a push when full replaces the oldest entry.
// Assumes the caller never pops an empty buffer; clear has priority.
module dbgtrig_trace #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_data,
    input  logic              pop,
    output logic [ADDR_W-1:0] head,
    output logic [CNT_W-1:0]  count,
    output logic              full
);

    logic [ADDR_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full = (count == CNT_W'(DEPTH));
    assign head = mem[rd_ptr];

    // Store pushed address at the write pointer.
    always_ff @(posedge clk) begin
        if (push && !clear) mem[wr_ptr] <= push_data;
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= nxt(wr_ptr);
            case ({push, pop})
                2'b10: begin
                    if (full) rd_ptr <= nxt(rd_ptr);
                    else      count  <= count + 1'b1;
                end
                2'b01: begin
                    rd_ptr <= nxt(rd_ptr);
                    count  <= count - 1'b1;
                end
                2'b11:   rd_ptr <= nxt(rd_ptr);
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dbgtrig_seq.sv
// Control register, run sequencing and break generation.
// Assumes trace_begin is stable while armed; a register write masks the bus that cycle.
module dbgtrig_seq
    import dbgtrig_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wdata,
    input  logic             secure,
    input  logic             trace_begin,
    input  logic             bus_valid,
    input  logic             hit,
    input  logic             pop_req,
    input  logic [CNT_W-1:0] count,
    output dbg_ctrl_t        ctrl,
    output logic             armed_flag,
    output logic             push,
    output logic             clear,
    output logic             pop,
    output logic             brk_tag,
    output logic             brk_force
);

    logic      seen;
    logic      acc, take, done;
    dbg_ctrl_t wr_val;

    // Written value after secure and enable gating.
    always_comb begin
        wr_val     = dbg_ctrl_t'(wdata);
        wr_val.en  = wdata[7] && !secure;
        wr_val.arm = wdata[6] && wr_val.en;
    end

    // Per-cycle capture and completion decisions.
    always_comb begin
        acc   = ctrl.arm && bus_valid && !wr_en;
        take  = trace_begin ? (seen || hit) : 1'b1;
        push  = acc && take;
        done  = acc && (trace_begin ? (take && count == CNT_W'(DEPTH - 1)) : hit);
        clear = wr_en && wr_val.arm;
        pop   = pop_req && !wr_en && !ctrl.arm && (count != '0);
    end

    // Register, run state and break pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl       <= '0;
            armed_flag <= 1'b0;
            seen       <= 1'b0;
            brk_tag    <= 1'b0;
            brk_force  <= 1'b0;
        end else begin
            brk_tag   <= done && ctrl.brk_en && ctrl.tag;
            brk_force <= done && ctrl.brk_en && !ctrl.tag;
            if (wr_en) begin
                ctrl       <= wr_val;
                armed_flag <= wr_val.arm;
                if (wr_val.arm) seen <= 1'b0;
            end else if (acc) begin
                if (hit) seen <= 1'b1;
                if (done) ctrl.arm <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/dbgtrig_unit.sv
// Top of the bus-match debug trigger unit: comparators, sequencer and trace buffer.
// Assumes comparator addresses are held stable by the host while armed.
module dbgtrig_unit
    import dbgtrig_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int TRACE_DEPTH = 8,
    localparam int CNT_W = $clog2(TRACE_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              secure,
    input  logic              trace_begin,
    input  logic [ADDR_W-1:0] cmp_a_addr,
    input  logic [ADDR_W-1:0] cmp_b_addr,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              trace_pop,
    output logic [ADDR_W-1:0] trace_data,
    output logic [CNT_W-1:0]  trace_count,
    output logic              trace_full,
    output logic              armed_flag,
    output logic              brk_tag,
    output logic              brk_force
);

    dbg_ctrl_t         ctrl;
    logic [ADDR_W-1:0] cmp_addr [NUM_CMP];
    logic              cmp_val  [NUM_CMP];
    logic              cmp_qual [NUM_CMP];
    logic [NUM_CMP-1:0] hits;
    logic              push, clear, pop;

    // Route per-comparator settings.
    always_comb begin
        cmp_addr[0] = cmp_a_addr;
        cmp_addr[1] = cmp_b_addr;
        cmp_val[0]  = ctrl.rw_a;
        cmp_qual[0] = ctrl.rw_a_en;
        cmp_val[1]  = ctrl.rw_b;
        cmp_qual[1] = ctrl.rw_b_en;
    end

    for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
        dbgtrig_cmp #(.ADDR_W(ADDR_W)) cmp_i (
            .cmp_addr (cmp_addr[i]),
            .rw_val   (cmp_val[i]),
            .rw_qual  (cmp_qual[i]),
            .bus_valid(bus_valid),
            .bus_addr (bus_addr),
            .bus_rd   (bus_rd),
            .hit      (hits[i])
        );
    end

    dbgtrig_seq #(.DEPTH(TRACE_DEPTH)) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr_en),
        .wdata      (reg_wdata),
        .secure     (secure),
        .trace_begin(trace_begin),
        .bus_valid  (bus_valid),
        .hit        (|hits),
        .pop_req    (trace_pop),
        .count      (trace_count),
        .ctrl       (ctrl),
        .armed_flag (armed_flag),
        .push       (push),
        .clear      (clear),
        .pop        (pop),
        .brk_tag    (brk_tag),
        .brk_force  (brk_force)
    );

    dbgtrig_trace #(.DEPTH(TRACE_DEPTH), .ADDR_W(ADDR_W)) trace_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .push     (push),
        .push_data(bus_addr),
        .pop      (pop),
        .head     (trace_data),
        .count    (trace_count),
        .full     (trace_full)
    );

    assign reg_rdata = ctrl;

endmodule

// File: rtl/dbgtrig_chk.sv
// Port-level property checker for dbgtrig_unit, attached by bind.
// Assumes synchronous active-low reset; all properties disabled in reset.
module dbgtrig_chk #(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr_en,
    input logic [7:0]       reg_rdata,
    input logic             secure,
    input logic             bus_valid,
    input logic [CNT_W-1:0] trace_count,
    input logic             trace_full,
    input logic             brk_tag,
    input logic             brk_force
);

    assert_secure_blocks_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && secure) |=> !reg_rdata[7]);

    assert_arm_needs_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[6] |-> reg_rdata[7]);

    assert_brk_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(brk_tag && brk_force));

    assert_tag_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        brk_tag |=> !brk_tag);

    assert_force_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        brk_force |=> !brk_force);

    assert_brk_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_tag || brk_force) |-> reg_rdata[4]);

    assert_tag_kind_R8: assert property (@(posedge clk) disable iff (!rst_n)
        brk_tag |-> reg_rdata[5]);

    assert_arm_clear_on_brk_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_tag || brk_force) |-> !reg_rdata[6]);

    assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (trace_count <= CNT_W'(DEPTH)) && (trace_full == (trace_count == CNT_W'(DEPTH))));

    assert_pop_ignored_armed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[6] && !bus_valid && !reg_wr_en) |=> $stable(trace_count));

    assert_write_masks_bus_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && !(reg_rdata[6] == 1'b0)) |=> (!brk_tag && !brk_force));

endmodule

bind dbgtrig_unit dbgtrig_chk #(.DEPTH(TRACE_DEPTH)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr_en  (reg_wr_en),
    .reg_rdata  (reg_rdata),
    .secure     (secure),
    .bus_valid  (bus_valid),
    .trace_count(trace_count),
    .trace_full (trace_full),
    .brk_tag    (brk_tag),
    .brk_force  (brk_force)
);

// File: tb/dbgtrig_unit_tb_top.sv
// Bench for dbgtrig_unit: behavioural model compared on every clock.
module dbgtrig_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        secure = 1'b0;
    logic        trace_begin = 1'b0;
    logic [15:0] cmp_a_addr = 16'h1234;
    logic [15:0] cmp_b_addr = 16'hBEEF;
    logic        bus_valid = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        trace_pop = 1'b0;
    logic [15:0] trace_data;
    logic [3:0]  trace_count;
    logic        trace_full;
    logic        armed_flag;
    logic        brk_tag;
    logic        brk_force;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    dbgtrig_unit dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .secure(secure), .trace_begin(trace_begin),
        .cmp_a_addr(cmp_a_addr), .cmp_b_addr(cmp_b_addr), .bus_valid(bus_valid),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .trace_pop(trace_pop),
        .trace_data(trace_data), .trace_count(trace_count), .trace_full(trace_full),
        .armed_flag(armed_flag), .brk_tag(brk_tag), .brk_force(brk_force)
    );

    // Reference model state
    logic [7:0]  m_reg = '0;
    bit          m_armf = 0, m_seen = 0, m_bt = 0, m_bf = 0;
    logic [15:0] m_q[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_reg = '0; m_armf = 0; m_seen = 0; m_bt = 0; m_bf = 0; m_q.delete();
        end else begin
            bit hit, done;
            m_bt = 0; m_bf = 0; done = 0;
            hit = bus_valid &&
                  ((bus_addr == cmp_a_addr && (!m_reg[2] || bus_rd == m_reg[3])) ||
                   (bus_addr == cmp_b_addr && (!m_reg[0] || bus_rd == m_reg[1])));
            if (reg_wr_en) begin
                m_reg = reg_wdata;
                m_reg[7] = reg_wdata[7] && !secure;
                m_reg[6] = reg_wdata[6] && m_reg[7];
                m_armf = m_reg[6];
                if (m_reg[6]) begin m_q.delete(); m_seen = 0; end
            end else if (m_reg[6]) begin
                if (bus_valid) begin
                    if (!trace_begin) begin
                        if (m_q.size() == 8) void'(m_q.pop_front());
                        m_q.push_back(bus_addr);
                        done = hit;
                    end else if (m_seen || hit) begin
                        m_seen = 1;
                        m_q.push_back(bus_addr);
                        done = (m_q.size() == 8);
                    end
                    if (done) begin
                        m_reg[6] = 0;
                        m_bt = m_reg[4] && m_reg[5];
                        m_bf = m_reg[4] && !m_reg[5];
                    end
                end
            end else if (trace_pop && m_q.size() > 0) begin
                void'(m_q.pop_front());
            end
        end
    end

    task automatic cmp(input string tag, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Compare every field away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            cmp("R1 reg_rdata", reg_rdata, m_reg);
            cmp("R3 armed_flag", armed_flag, m_armf);
            cmp("R6/R7 trace_count", trace_count, m_q.size());
            cmp("R10 trace_full", trace_full, m_q.size() == 8);
            if (m_q.size() > 0) cmp("R10 trace_data", trace_data, m_q[0]);
            cmp("R8 brk_tag", brk_tag, m_bt);
            cmp("R8 brk_force", brk_force, m_bf);
        end
    end

    task automatic cyc(input bit w, input logic [7:0] wd, input bit v,
                       input logic [15:0] a, input bit rd, input bit p);
        @(negedge clk);
        reg_wr_en = w; reg_wdata = wd; bus_valid = v; bus_addr = a; bus_rd = rd; trace_pop = p;
    endtask

    task automatic wr(input logic [7:0] d);  cyc(1, d, 0, 0, 0, 0); endtask
    task automatic acc(input logic [15:0] a, input bit rd); cyc(0, 0, 1, a, rd, 0); endtask
    task automatic idle(); cyc(0, 0, 0, 0, 0, 0); endtask
    task automatic pop1(); cyc(0, 0, 0, 0, 0, 1); endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();
        @(negedge clk);
        cmp("R1 reset value", reg_rdata, 8'h00);

        // R2: secure blocks enable and arm
        secure = 1'b1;
        wr(8'hD0); idle();
        @(negedge clk);
        cmp("R2 secure write", reg_rdata, 8'h10);
        secure = 1'b0;
        wr(8'h40); idle();            // arm without enable
        @(negedge clk);
        cmp("R2 arm needs enable", reg_rdata[6], 0);

        // R6 R8 force break, end mode with wraparound
        trace_begin = 1'b0;
        wr(8'hD0); idle();
        @(negedge clk);
        cmp("R3 armed", armed_flag, 1);
        for (int i = 0; i < 11; i++) acc(16'h0100 + 16'(i), i[0]);
        acc(16'h1234, 0);
        idle(); idle();
        @(negedge clk);
        cmp("R9 arm cleared", reg_rdata[6], 0);
        cmp("R3 flag holds", armed_flag, 1);
        cmp("R6 count", trace_count, 8);
        for (int i = 0; i < 8; i++) pop1();
        idle();

        // R5 R7 tag break, begin mode, A qualified on reads
        trace_begin = 1'b1;
        wr(8'hFC);
        acc(16'h1234, 0);             // write: ignored by A
        acc(16'h2222, 1);
        acc(16'h1234, 1);             // trigger
        for (int i = 0; i < 9; i++) acc(16'h3000 + 16'(i), 0);
        idle(); idle();
        @(negedge clk);
        cmp("R7 full count", trace_count, 8);
        cmp("R7 first entry", trace_data, 16'h1234);
        for (int i = 0; i < 3; i++) pop1();

        // R5 comparator B qualified on writes, breaks disabled
        trace_begin = 1'b0;
        wr(8'hC1);
        acc(16'hBEEF, 1);             // read: ignored by B
        acc(16'h0050, 0);
        acc(16'hBEEF, 0);             // trigger
        acc(16'h0060, 0);
        idle();
        @(negedge clk);
        cmp("R8 no break when disabled", brk_tag | brk_force, 0);

        // R4 manual stop, R10 pop ignored while armed, R11 write masks bus
        wr(8'hE0);
        acc(16'h0701, 0);
        pop1(); pop1();
        cyc(1, 8'hE0, 1, 16'h1234, 0, 0); // rewrite arm with trigger on bus
        acc(16'h0702, 1);
        wr(8'h80);                    // stop
        acc(16'h1234, 0);
        acc(16'h0703, 0);
        idle(); idle();
        @(negedge clk);
        cmp("R4 stopped count", trace_count, 1);
        cmp("R11 no break", brk_tag | brk_force, 0);
        pop1(); pop1(); idle();

        // R8 one break per run: later triggers after completion do nothing
        wr(8'hD0);
        acc(16'h1234, 1);
        acc(16'h1234, 1);
        acc(16'hBEEF, 0);
        idle(); idle();
        repeat (3) @(negedge clk);
        summary();
    end

endmodule